// File: doc/BRIEF.md
# Accumulator Arithmetic-Logic Unit with Packed Status Flags

This block performs one 8-bit arithmetic, logic, rotate or decimal-correction operation per clock on an accumulator value and a second operand. The result appears combinationally in the same cycle. Five status bits are kept in an internal register: sign, zero, even parity, half carry and carry. That register updates on the clock edge that ends an accepted operation. Each operation class follows its own flag rule, so a sequencer can chain operations such as multi-byte adds and decimal adds without extra logic.

The status register is read out as one packed byte. A sequencer can also load it as one byte, for example to restore it after a context switch. The fixed bits of that byte are forced on load. An operation is accepted in every cycle in which `op_valid` is high. The block never stalls, so there is no back-pressure path. The sequencer writes `result` into its accumulator only when `acc_we` is high. The register file, instruction fetch and memory are outside this block.

Top module: `alu8_flags_unit`

## Requirements
- R1: After reset the flag byte reads 0x02. Layout, MSB first: sign, zero, 0, half carry, 0, parity, 1, carry.
- R2: Code 0 (add) gives acc+opnd. Code 1 (add with carry) also adds the current carry. Carry is the bit out of bit 7.
- R3: Code 2 (subtract) gives acc-opnd. Code 3 (subtract with borrow) also subtracts the current carry. Carry is set when opnd plus the subtracted carry exceeds acc, read as unsigned values.
- R4: On the add codes, half carry is the carry out of bit 3. On the subtract and compare codes, half carry is set when the low nibble of opnd plus the subtracted carry exceeds the low nibble of acc.
- R5: Every operation that updates all flags sets sign to bit 7 of its value, zero when that value is 0, and parity when the value holds an even number of ones.
- R6: Codes 4, 5 and 6 give AND, OR and XOR of acc and opnd. They clear carry and half carry.
- R7: Code 7 (compare) sets every flag as code 2 would. It keeps `result` equal to acc and holds `acc_we` low.
- R8: Code 8 (increment acc) and code 9 (decrement acc) update sign, zero, parity and half carry, and keep carry. Half carry is set on 0xF to 0x0 in the low nibble for increment, and on 0x0 to 0xF for decrement.
- R9: Codes 10 to 13 rotate acc. Code 10 rotates left and copies bit 7 to carry. Code 11 rotates right and copies bit 0 to carry. Code 12 rotates left through carry. Code 13 rotates right through carry. These codes change only carry.
- R10: Code 14 writes ~acc and leaves all flags alone. Code 15 inverts carry and code 16 sets carry. Neither code 15 nor code 16 writes the accumulator or changes any other flag.
- R11: Code 17 (decimal adjust) first adds 0x06 when the low nibble exceeds 9 or half carry is set. It then adds 0x60 when the high nibble of that sum exceeds 9, when that first add carried out of bit 7, or when carry is set. Carry then reads 1 if and only if the second add took place. Half carry is the carry out of bit 3 of the first add.
- R12: `flag_load` writes `flag_load_val` into the flag byte with bits 5 and 3 forced to 0 and bit 1 forced to 1. It takes priority over an operation in the same cycle.
- R13: With `op_valid` low, or with a code of 18 or above, the flags hold and `acc_we` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation select, codes 0 to 17 |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| flag_load | input | 1 | Load the flag byte |
| flag_load_val | input | 8 | Flag byte to load |
| result | output | 8 | Combinational operation result |
| acc_we | output | 1 | Result should be written to the accumulator |
| flags | output | 8 | Registered packed flag byte |

## Verification
The bench builds the block with its default 8-bit data width and 4-bit nibble width. At this width a few short operand choices reach every flag corner. These include a wrap through 0xFF to 0x00, a low-nibble carry such as 0x0F+0x08, a borrow from a smaller accumulator, and decimal sums that need one correction, both corrections, or a carry out. Because carry feeds into add-with-carry, subtract-with-borrow, the carry rotates and decimal adjust, the bench chains operations back to back. That way each carry-consuming code sees the flag left by the previous cycle.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;
  localparam int unsigned OP_W   = 5;

  // packed flag byte bit positions
  localparam int unsigned FB_CY = 0;
  localparam int unsigned FB_P  = 2;
  localparam int unsigned FB_AC = 4;
  localparam int unsigned FB_Z  = 6;
  localparam int unsigned FB_S  = 7;
  localparam logic [7:0] FLAG_KEEP  = 8'hD5;
  localparam logic [7:0] FLAG_FIXED = 8'h02;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_CMP = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_CMC = 5'd15,
    OP_STC = 5'd16, OP_DAA = 5'd17
  } op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;
endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith #(
  parameter int unsigned W  = 8,
  parameter int unsigned NW = W / 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         ac
);
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   full;
  logic [NW:0]  low;

  always_comb begin
    // subtraction as a + ~b + ~cin, borrow is the inverted carry
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    low   = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
    res   = full[W-1:0];
    cy    = full[W] ^ sub;
    ac    = low[NW] ^ sub;
  end
endmodule

// File: rtl/alu8_rotate.sv
`timescale 1ns/1ps
module alu8_rotate #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic [1:0]   sel,   // 0 left, 1 right, 2 left via carry, 3 right via carry
  output logic [W-1:0] res,
  output logic         cy
);
  logic through;
  logic fill_l, fill_r;

  always_comb begin
    through = sel[1];
    fill_l  = through ? cin : a[W-1];
    fill_r  = through ? cin : a[0];
    if (sel[0]) begin
      res = {fill_r, a[W-1:1]};
      cy  = a[0];
    end else begin
      res = {a[W-2:0], fill_l};
      cy  = a[W-1];
    end
  end
endmodule

// File: rtl/alu8_decadj.sv
`timescale 1ns/1ps
module alu8_decadj
  import alu8_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic              ac_in,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res,
  output logic              ac_out,
  output logic              cy_out
);
  localparam logic [NIB_W-1:0] NINE = NIB_W'(9);
  localparam logic [DATA_W:0]  LO_FIX = (DATA_W+1)'(6);
  localparam logic [DATA_W:0]  HI_FIX = (DATA_W+1)'(6) << NIB_W;

  logic            lo_adj, hi_adj;
  logic [DATA_W:0] stage1;
  logic [NIB_W:0]  lo_sum;

  always_comb begin
    lo_adj = (a[NIB_W-1:0] > NINE) || ac_in;
    stage1 = {1'b0, a} + (lo_adj ? LO_FIX : '0);
    lo_sum = {1'b0, a[NIB_W-1:0]} + (lo_adj ? (NIB_W+1)'(6) : '0);
    hi_adj = (stage1[DATA_W-1:NIB_W] > NINE) || stage1[DATA_W] || cy_in;
    res    = stage1[DATA_W-1:0] + (hi_adj ? HI_FIX[DATA_W-1:0] : '0);
    ac_out = lo_sum[NIB_W];
    cy_out = hi_adj;
  end
endmodule

// File: rtl/alu8_flags_unit.sv
`timescale 1ns/1ps
module alu8_flags_unit
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic              flag_load,
  input  logic [7:0]        flag_load_val,
  output logic [DATA_W-1:0] result,
  output logic              acc_we,
  output logic [7:0]        flags
);
  localparam logic [7:0] RESET_FLAGS = FLAG_FIXED;

  logic [7:0]        flags_q;
  flags_t            cur, nxt;
  op_e               op;

  logic [DATA_W-1:0] ar_b, ar_res, rot_res, daa_res, res_c;
  logic              ar_cin, ar_sub, ar_cy, ar_ac;
  logic              rot_cy, daa_ac, daa_cy;
  logic [1:0]        rot_sel;
  logic              we_c, set_szp;

  assign op = op_e'(op_code);
  assign cur.s  = flags_q[FB_S];
  assign cur.z  = flags_q[FB_Z];
  assign cur.ac = flags_q[FB_AC];
  assign cur.p  = flags_q[FB_P];
  assign cur.cy = flags_q[FB_CY];

  // operand steering for the shared adder
  always_comb begin
    ar_b   = opnd_in;
    ar_cin = 1'b0;
    ar_sub = 1'b0;
    unique case (op)
      OP_ADC:         ar_cin = cur.cy;
      OP_SUB, OP_CMP: ar_sub = 1'b1;
      OP_SBB: begin ar_sub = 1'b1; ar_cin = cur.cy; end
      OP_INC: begin ar_b = '0; ar_cin = 1'b1; end
      OP_DEC: begin ar_b = '0; ar_cin = 1'b1; ar_sub = 1'b1; end
      default: ;
    endcase
    rot_sel = op_code[1:0] - 2'd2;   // codes 10..13 map to 0..3
  end

  alu8_arith #(.W(DATA_W), .NW(NIB_W)) u_arith (
    .a(acc_in), .b(ar_b), .cin(ar_cin), .sub(ar_sub),
    .res(ar_res), .cy(ar_cy), .ac(ar_ac)
  );

  alu8_rotate #(.W(DATA_W)) u_rot (
    .a(acc_in), .cin(cur.cy), .sel(rot_sel), .res(rot_res), .cy(rot_cy)
  );

  alu8_decadj u_daa (
    .a(acc_in), .ac_in(cur.ac), .cy_in(cur.cy),
    .res(daa_res), .ac_out(daa_ac), .cy_out(daa_cy)
  );

  // per-class result and flag rules
  logic [DATA_W-1:0] szp_src;
  always_comb begin
    res_c   = acc_in;
    we_c    = 1'b0;
    nxt     = cur;
    set_szp = 1'b0;
    szp_src = ar_res;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_c = ar_res; we_c = 1'b1;
        nxt.cy = ar_cy; nxt.ac = ar_ac; set_szp = 1'b1;
      end
      OP_CMP: begin
        nxt.cy = ar_cy; nxt.ac = ar_ac; set_szp = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_c = (op == OP_AND) ? (acc_in & opnd_in) :
                (op == OP_OR)  ? (acc_in | opnd_in) : (acc_in ^ opnd_in);
        we_c = 1'b1; nxt.cy = 1'b0; nxt.ac = 1'b0;
        set_szp = 1'b1; szp_src = res_c;
      end
      OP_INC, OP_DEC: begin
        res_c = ar_res; we_c = 1'b1; nxt.ac = ar_ac; set_szp = 1'b1;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        res_c = rot_res; we_c = 1'b1; nxt.cy = rot_cy;
      end
      OP_CMA: begin
        res_c = ~acc_in; we_c = 1'b1;
      end
      OP_CMC: nxt.cy = ~cur.cy;
      OP_STC: nxt.cy = 1'b1;
      OP_DAA: begin
        res_c = daa_res; we_c = 1'b1; nxt.ac = daa_ac; nxt.cy = daa_cy;
        set_szp = 1'b1; szp_src = daa_res;
      end
      default: ;
    endcase
    if (set_szp) begin
      nxt.s = szp_src[DATA_W-1];
      nxt.z = ~|szp_src;
      nxt.p = ~^szp_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= RESET_FLAGS;
    else if (flag_load)
      flags_q <= (flag_load_val & FLAG_KEEP) | FLAG_FIXED;
    else if (op_valid)
      flags_q <= {nxt.s, nxt.z, 1'b0, nxt.ac, 1'b0, nxt.p, 1'b1, nxt.cy};
  end

  assign result = res_c;
  assign acc_we = op_valid & we_c;
  assign flags  = flags_q;
endmodule

// File: rtl/alu8_checker.sv
`timescale 1ns/1ps
module alu8_checker
  import alu8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [OP_W-1:0]   op_code,
  input logic [DATA_W-1:0] acc_in,
  input logic              flag_load,
  input logic [7:0]        flag_load_val,
  input logic [DATA_W-1:0] result,
  input logic              acc_we,
  input logic [7:0]        flags
);
  logic go;
  assign go = op_valid && !flag_load;

  p_fixed_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[5] && !flags[3] && flags[1]);
  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> flags == (($past(flag_load_val) & FLAG_KEEP) | FLAG_FIXED));
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !flag_load) |=> $stable(flags));
  p_no_we_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code > 5'd17) |-> !acc_we);
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_code == OP_ADD) |=> flags[FB_Z] == ($past(result) == '0));
  p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_code == OP_XOR) |=> flags[FB_P] == ~^$past(result));
  p_logic_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
      |=> !flags[FB_CY] && !flags[FB_AC]);
  p_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |-> !acc_we && result == acc_in);
  p_incdec_cy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op_code == OP_INC || op_code == OP_DEC)) |=> flags[FB_CY] == $past(flags[FB_CY]));
  p_rot_only_cy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_code >= OP_RLC && op_code <= OP_RAR) |=> flags[7:1] == $past(flags[7:1]));
  p_cma_val_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMA) |-> acc_we && result == ~acc_in);
  p_cma_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_code == OP_CMA) |=> $stable(flags));
  p_stc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_code == OP_STC) |=> flags[FB_CY] && flags[7:1] == $past(flags[7:1]));
endmodule

bind alu8_flags_unit alu8_checker i_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .acc_in(acc_in), .flag_load(flag_load), .flag_load_val(flag_load_val),
  .result(result), .acc_we(acc_we), .flags(flags)
);

// File: tb/test_alu8_flags_unit.sv
`timescale 1ns/1ps
module test_alu8_flags_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic       flag_load = 1'b0;
  logic [7:0] flag_load_val = '0;
  logic [7:0] result;
  logic       acc_we;
  logic [7:0] flags;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl_flags = 8'h02;

  typedef struct {
    logic       chk_res;
    logic [7:0] res;
    logic       we;
    logic [7:0] fl;
    string      tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;   // 50 MHz

  alu8_flags_unit i_alu8_flags_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .flag_load(flag_load),
    .flag_load_val(flag_load_val), .result(result), .acc_we(acc_we), .flags(flags)
  );

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic logic [16:0] model(input logic [4:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    logic s, z, ac, p, cy, we, szp, cin;
    logic [7:0] r, v;
    logic [8:0] t;
    int d;
    s = f[7]; z = f[6]; ac = f[4]; p = f[2]; cy = f[0];
    we = 1'b1; szp = 1'b0; r = a; v = a;
    cin = (op == 5'd1 || op == 5'd3) ? cy : 1'b0;
    case (op)
      5'd0, 5'd1: begin
        t = 9'(a) + 9'(b) + 9'(cin);
        r = t[7:0]; cy = t[8]; ac = (int'(a[3:0]) + int'(b[3:0]) + int'(cin)) > 15;
        v = r; szp = 1'b1;
      end
      5'd2, 5'd3, 5'd7: begin
        d = int'(a) - int'(b) - int'(cin);
        v = 8'(d); cy = (int'(b) + int'(cin)) > int'(a);
        ac = (int'(b[3:0]) + int'(cin)) > int'(a[3:0]); szp = 1'b1;
        if (op == 5'd7) begin r = a; we = 1'b0; end else r = v;
      end
      5'd4, 5'd5, 5'd6: begin
        r = (op == 5'd4) ? (a & b) : (op == 5'd5) ? (a | b) : (a ^ b);
        cy = 1'b0; ac = 1'b0; v = r; szp = 1'b1;
      end
      5'd8: begin r = a + 8'd1; ac = (a[3:0] == 4'hF); v = r; szp = 1'b1; end
      5'd9: begin r = a - 8'd1; ac = (a[3:0] == 4'h0); v = r; szp = 1'b1; end
      5'd10: begin r = {a[6:0], a[7]}; cy = a[7]; end
      5'd11: begin r = {a[0], a[7:1]}; cy = a[0]; end
      5'd12: begin r = {a[6:0], cy}; cy = a[7]; end
      5'd13: begin r = {cy, a[7:1]}; cy = a[0]; end
      5'd14: r = ~a;
      5'd15: begin cy = ~cy; we = 1'b0; end
      5'd16: begin cy = 1'b1; we = 1'b0; end
      5'd17: begin
        logic lo, hi;
        lo = (a[3:0] > 4'd9) || ac;
        t = 9'(a) + (lo ? 9'd6 : 9'd0);
        ac = lo && (int'(a[3:0]) + 6 > 15);
        hi = (t[7:4] > 4'd9) || t[8] || cy;
        r = t[7:0] + (hi ? 8'h60 : 8'h00);
        cy = hi; v = r; szp = 1'b1;
      end
      default: we = 1'b0;
    endcase
    if (szp) begin s = v[7]; z = (v == 8'h00); p = ~^v; end
    return {we, r, s, z, 1'b0, ac, 1'b0, p, 1'b1, cy};
  endfunction

  // driver: one cycle per call, pushes the expected outcome
  task automatic drive(input logic vld, input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic ld, input logic [7:0] lv, input string tag);
    item_t it;
    logic [16:0] m;
    @(posedge clk); #4;
    op_valid = vld; op_code = op; acc_in = a; opnd_in = b;
    flag_load = ld; flag_load_val = lv;
    m = model(op, a, b, mdl_flags);
    it.tag = tag;
    it.chk_res = vld && !ld;
    it.res = m[15:8];
    it.we  = vld ? m[16] : 1'b0;
    if (ld)       it.fl = (lv & 8'hD5) | 8'h02;
    else if (vld) it.fl = m[7:0];
    else          it.fl = mdl_flags;
    mdl_flags = it.fl;
    sb.push_back(it);
  endtask

  task automatic op1(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b, input string tag);
    drive(1'b1, op, a, b, 1'b0, 8'h00, tag);
  endtask

  // monitor: result in the cycle of the operation, flags one edge later
  initial begin
    item_t cur;
    logic pend = 1'b0;
    logic [7:0] pf = '0;
    string ptag = "";
    forever begin
      @(posedge clk); #8;
      if (pend) check(ptag, "flags", flags, pf);
      pend = 1'b0;
      if (sb.size() > 0) begin
        cur = sb.pop_front();
        check(cur.tag, "acc_we", {7'd0, acc_we}, {7'd0, cur.we});
        if (cur.chk_res) check(cur.tag, "result", result, cur.res);
        pf = cur.fl; ptag = cur.tag; pend = 1'b1;
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #4 check("R1", "reset flags", flags, 8'h02);
    rst_n = 1'b1;
    // R2 / R4 / R5 adds
    op1(5'd0, 8'h0F, 8'h08, "R4");
    op1(5'd0, 8'hFF, 8'h01, "R2");
    op1(5'd1, 8'h10, 8'h20, "R2");
    op1(5'd0, 8'h7F, 8'h01, "R5");
    // R3 subtract / borrow
    op1(5'd2, 8'h05, 8'h07, "R3");
    op1(5'd3, 8'h10, 8'h01, "R3");
    op1(5'd2, 8'h42, 8'h42, "R5");
    op1(5'd2, 8'h20, 8'h01, "R4");
    // R6 logic
    op1(5'd16, 8'h00, 8'h00, "R10");
    op1(5'd4, 8'hF0, 8'h3C, "R6");
    op1(5'd5, 8'h81, 8'h02, "R6");
    op1(5'd6, 8'hAA, 8'hAA, "R6");
    // R7 compare
    op1(5'd7, 8'h03, 8'h09, "R7");
    op1(5'd7, 8'h33, 8'h33, "R7");
    // R8 increment / decrement keep carry
    op1(5'd16, 8'h00, 8'h00, "R10");
    op1(5'd8, 8'hFF, 8'h00, "R8");
    op1(5'd9, 8'h00, 8'h00, "R8");
    op1(5'd15, 8'h00, 8'h00, "R10");
    op1(5'd8, 8'h3E, 8'h00, "R8");
    op1(5'd9, 8'h81, 8'h00, "R8");
    // R9 rotates
    op1(5'd10, 8'h81, 8'h00, "R9");
    op1(5'd11, 8'h02, 8'h00, "R9");
    op1(5'd12, 8'h80, 8'h00, "R9");
    op1(5'd12, 8'h01, 8'h00, "R9");
    op1(5'd13, 8'h01, 8'h00, "R9");
    op1(5'd13, 8'h00, 8'h00, "R9");
    // R10 complement, carry ops
    op1(5'd14, 8'h5A, 8'h00, "R10");
    op1(5'd15, 8'h00, 8'h00, "R10");
    op1(5'd15, 8'h00, 8'h00, "R10");
    // R11 decimal adjust after decimal adds
    op1(5'd0, 8'h09, 8'h09, "R11");
    op1(5'd17, 8'h12, 8'h00, "R11");
    op1(5'd0, 8'h45, 8'h55, "R11");
    op1(5'd17, 8'h9A, 8'h00, "R11");
    op1(5'd0, 8'h99, 8'h99, "R11");
    op1(5'd17, 8'h32, 8'h00, "R11");
    op1(5'd2, 8'h00, 8'h00, "R11");
    op1(5'd17, 8'hFA, 8'h00, "R11");
    op1(5'd17, 8'h23, 8'h00, "R11");
    // R12 flag load, priority over operation
    drive(1'b0, 5'd0, 8'h00, 8'h00, 1'b1, 8'hFF, "R12");
    drive(1'b1, 5'd16, 8'h00, 8'h00, 1'b1, 8'h00, "R12");
    drive(1'b0, 5'd0, 8'h00, 8'h00, 1'b1, 8'h51, "R12");
    // R13 idle and unassigned codes
    drive(1'b0, 5'd0, 8'hFF, 8'h01, 1'b0, 8'h00, "R13");
    op1(5'd20, 8'h00, 8'h00, "R13");
    op1(5'd31, 8'h80, 8'h80, "R13");
    drive(1'b0, 5'd15, 8'h00, 8'h00, 1'b0, 8'h00, "R13");
    drive(1'b0, 5'd0, 8'h00, 8'h00, 1'b0, 8'h00, "R13");
    repeat (3) @(posedge clk);
    #9;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule